// File: doc/BRIEF.md
# Battery-Backed Byte-Wide Static Memory with Write Guard

A synthesizable model of a 2048 x 8 static memory. A host reaches it through active-low chip-select, output-enable and write-enable pins, an 11-bit address and split data-in, data-out and data-out-enable signals. A free-running clock samples every control pin. An access is therefore a run of sampled cycles, and each output follows its sampled input one clock later.

Three digital status inputs stand in for an analog supply monitor: supply in tolerance, supply inside the power-fail window, and running from battery. Unless the supply is in tolerance, outside the window and not on battery, the memory is cut off from its host. It drives nothing, accepts nothing and keeps what it stores.

A battery-low input is sampled when power becomes good. If it is high at that moment, a guard flag arms. The flag quietly discards the next write that completes, then clears itself.

Top module: `bbsram_top`

## Requirements
- R1: When power is good and chip-select is 0, output-enable is 0 and write-enable is 1 at a clock edge, `dout_en` is 1 after that edge and `dout` holds the byte stored at the sampled address. If a write to that same address completes at the same edge, `dout` holds the newly written byte.
- R2: While chip-select is 1, `dout_en` is 0 after the edge, and write-enable has no effect on memory contents.
- R3: With chip-select 0, write-enable 1 and output-enable 1, `dout_en` is 0 after the edge. Whenever no read is sampled, `dout` keeps its previous value.
- R4: A write is active in every cycle where power is good and both chip-select and write-enable are 0, whatever output-enable is doing. The write completes at the first edge where either pin has returned to 1. It stores the address and data sampled in the last active cycle. This holds whether write-enable, chip-select or both end the write.
- R5: When write-enable is sampled 0, `dout_en` is 0 after that edge, even if a read was being driven before.
- R6: Power is good only when `supply_ok` is 1, `fail_win` is 0 and `on_batt` is 0. When power is not good, `dout_en` is 0 after the edge, `dout` is held, and all access pins are ignored. Stored bytes survive until power returns.
- R7: A write whose active cycles are ended by power becoming not good stores nothing, and the addressed byte keeps its old value.
- R8: If `batt_low` is 1 at the first edge where power is good after an edge where it was not, a guard flag arms. The next write to complete is discarded and the flag clears, so every later write stores normally.
- R9: Reset disarms the guard flag but does not alter memory contents. After reset, `dout_en` and `dout` are 0.
- R10: A power-up with `batt_low` at 0 leaves the guard disarmed, and the first write after it stores normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply within operating tolerance |
| fail_win | input | 1 | Supply inside the power-fail deselect window |
| on_batt | input | 1 | Memory is running from the backup cell |
| batt_low | input | 1 | Backup cell voltage too low, sampled at power-up |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Read data bus drive enable; 0 means high impedance |

## Verification
The bench fills every one of the 2048 locations with an address-derived pattern. It rotates between ending each write with write-enable, with chip-select, with both, and with output-enable held low, then reads every byte back. A design that commits on the wrong edge, or only for one of the terminating pins, returns stale bytes in that sweep.

Directed sequences cover the remaining cases, each with a visible failure if handled wrongly:
- Changing data in the releasing cycle: a design that uses the last-cycle value instead of the held one stores the wrong byte.
- Reading in the same edge a write completes: a design with no forwarding returns the old byte.
- Writing during a power-fail window: a design that still honours the pins overwrites stored data.
- Losing power mid-write: a design that commits anyway corrupts the location.
- The guard flag: a design that blocks zero writes, or two, shows up in read-backs around a low-battery power-up and around a reset.

// File: rtl/bbsram_pkg.sv
package bbsram_pkg;

  // Sampled access kind; ACC_OFF covers both chip deselect and bad power.
  typedef enum logic [1:0] {
    ACC_OFF   = 2'd0,
    ACC_IDLE  = 2'd1,
    ACC_READ  = 2'd2,
    ACC_WRITE = 2'd3
  } acc_e;

  // Write-enable dominates output-enable; chip select and power gate all.
  function automatic acc_e decode_acc(input logic pwr_good, input logic ce_n,
                                      input logic oe_n, input logic we_n);
    if (!pwr_good || ce_n) return ACC_OFF;
    else if (!we_n)        return ACC_WRITE;
    else if (!oe_n)        return ACC_READ;
    else                   return ACC_IDLE;
  endfunction

endpackage

// File: rtl/bbsram_pwr.sv
module bbsram_pwr (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic fail_win,
  input  logic on_batt,
  input  logic batt_low,
  input  logic wr_done,
  output logic pwr_good,
  output logic wr_commit
);

  logic pg_q, pg_d;
  logic guard_q, guard_d;

  assign pwr_good  = supply_ok & ~fail_win & ~on_batt;
  assign wr_commit = wr_done & ~guard_q;

  always_comb begin
    pg_d    = pwr_good;
    guard_d = guard_q;
    if (pwr_good && !pg_q && batt_low) guard_d = 1'b1;
    else if (wr_done)                  guard_d = 1'b0;
  end

  // pg_q resets high so that leaving reset is not mistaken for a power-up.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q    <= 1'b1;
      guard_q <= 1'b0;
    end else begin
      pg_q    <= pg_d;
      guard_q <= guard_d;
    end
  end

endmodule

// File: rtl/bbsram_ctl.sv
module bbsram_ctl
  import bbsram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_commit,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wr_done,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  acc_e              acc;
  logic              wr_now, rd_now;
  logic              wr_act_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_data_q;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              den_q;
  logic [DATA_W-1:0] rd_byte;

  assign acc    = decode_acc(pwr_good, ce_n, oe_n, we_n);
  assign wr_now = (acc == ACC_WRITE);
  assign rd_now = (acc == ACC_READ);

  // A write ends when it was active and is no longer; bad power aborts it.
  assign wr_done = wr_act_q & ~wr_now & pwr_good;
  assign wr_addr = lat_addr_q;
  assign wr_data = lat_data_q;

  // Forward a byte committed at this very edge to a same-address read.
  assign rd_byte = (wr_commit && (lat_addr_q == addr)) ? lat_data_q : mem_rdata;

  always_comb begin
    dout_d = dout_q;
    if (rd_now) dout_d = rd_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q   <= 1'b0;
      lat_addr_q <= '0;
      lat_data_q <= '0;
      den_q      <= 1'b0;
      dout_q     <= '0;
    end else begin
      wr_act_q <= wr_now;
      den_q    <= rd_now;
      dout_q   <= dout_d;
      if (wr_now) begin
        lat_addr_q <= addr;
        lat_data_q <= din;
      end
    end
  end

  assign dout    = dout_q;
  assign dout_en = den_q;

endmodule

// File: rtl/bbsram_array.sv
module bbsram_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // Storage is deliberately outside reset: contents must survive it.
  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/bbsram_top.sv
module bbsram_top #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              fail_win,
  input  logic              on_batt,
  input  logic              batt_low,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic              pwr_good;
  logic              wr_done, wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data, mem_rdata;

  bbsram_pwr pwr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .fail_win  (fail_win),
    .on_batt   (on_batt),
    .batt_low  (batt_low),
    .wr_done   (wr_done),
    .pwr_good  (pwr_good),
    .wr_commit (wr_commit)
  );

  bbsram_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .addr      (addr),
    .din       (din),
    .wr_commit (wr_commit),
    .mem_rdata (mem_rdata),
    .wr_done   (wr_done),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .dout      (dout),
    .dout_en   (dout_en)
  );

  bbsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk     (clk),
    .wr_en   (wr_commit),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (addr),
    .rd_data (mem_rdata)
  );

endmodule

// File: rtl/bbsram_chk.sv
module bbsram_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic              fail_win,
  input logic              on_batt,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);

  logic pg_seen;
  assign pg_seen = supply_ok && !fail_win && !on_batt;

  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_seen && !ce_n && !oe_n && we_n) |=> dout_en);

  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dout_en);

  assert_oe_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !dout_en);

  assert_write_offbus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> !dout_en);

  assert_pwr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_seen |=> !dout_en);

  assert_pwr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_seen |=> $stable(dout));

endmodule

bind bbsram_top bbsram_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .fail_win  (fail_win),
  .on_batt   (on_batt),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .dout      (dout),
  .dout_en   (dout_en)
);

// File: tb/bbsram_top_tb_top.sv
module bbsram_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b1, fail_win = 1'b0, on_batt = 1'b0, batt_low = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bbsram_top dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .fail_win(fail_win),
    .on_batt(on_batt), .batt_low(batt_low), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13) + (a >> 4)) ^ 8'hA5;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic o, input logic w,
                       input int a, input logic [7:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; addr = 11'(a); din = d;
  endtask

  task automatic set_pwr(input logic ok, input logic win, input logic bat);
    @(negedge clk);
    supply_ok = ok; fail_win = win; on_batt = bat;
  endtask

  // style: 0 write-enable ends, 1 chip-select ends, 2 both end, 3 oe held low
  task automatic wr(input int a, input logic [7:0] d, input int style);
    case (style)
      0: begin drive(0,1,0,a,d); drive(0,1,1,a,d); end
      1: begin drive(0,1,0,a,d); drive(1,1,0,a,d); end
      2: begin drive(0,1,0,a,d); end
      default: begin drive(0,0,0,a,d); drive(1,0,0,a,d); end
    endcase
    drive(1,1,1,a,d);
  endtask

  task automatic rd(input int a, output logic en, output logic [7:0] d);
    drive(0,0,1,a,8'h00);
    @(negedge clk);
    en = dout_en; d = dout;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic rd_expect(input string req, input int a, input logic [7:0] exp);
    logic en; logic [7:0] d;
    rd(a, en, d);
    chk({req, " enable"}, en, 1);
    chk({req, " data"}, d, exp);
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic en; logic [7:0] d;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset dout_en", dout_en, 0);
    chk("R9 reset dout", dout, 0);
    rst_n = 1;

    // R4 sweep: fill every location, rotating termination style
    for (int a = 0; a < 2048; a++) wr(a, pat(a), a % 4);
    // R1 sweep: read back every location
    for (int a = 0; a < 2048; a++) begin
      rd(a, en, d);
      chk("R1 sweep enable", en, 1);
      chk("R4 sweep data", d, pat(a));
    end

    // R4: data changed in the releasing cycle is not stored
    drive(0,1,0,50,8'h11); drive(0,1,1,50,8'h22); drive(1,1,1,50,8'h22);
    rd_expect("R4 held data", 50, 8'h11);

    // R2: writes and reads ignored while deselected
    drive(1,1,0,40,8'h00); drive(1,1,1,40,8'h00);
    rd_expect("R2 no write deselected", 40, pat(40));
    drive(1,0,1,40,8'h00); @(negedge clk);
    chk("R2 deselected bus", dout_en, 0);

    // R3: output enable high keeps bus off and dout held
    drive(0,1,1,41,8'h00); @(negedge clk);
    chk("R3 oe high bus", dout_en, 0);
    chk("R3 dout held", dout, pat(40));

    // R5: write-enable falling during read turns bus off; R1 forwarding
    drive(0,0,1,60,8'h00); @(negedge clk);
    chk("R5 read before", dout_en, 1);
    drive(0,0,0,60,8'h99); @(negedge clk);
    chk("R5 write turns bus off", dout_en, 0);
    drive(0,0,1,60,8'h99); @(negedge clk);
    chk("R1 forward enable", dout_en, 1);
    chk("R1 forward data", dout, 8'h99);
    drive(1,1,1,0,8'h00);

    // R6: power-fail window and battery: ignored, bus off, contents kept
    set_pwr(1,1,0);
    wr(5, 8'h00, 0);
    rd(5, en, d);
    chk("R6 window bus", en, 0);
    set_pwr(0,0,1);
    rd(5, en, d);
    chk("R6 battery bus", en, 0);
    set_pwr(1,0,0);
    rd_expect("R6 contents kept", 5, pat(5));
    // R10: power-up with battery fine does not block
    wr(5, 8'h5E, 1);
    rd_expect("R10 first write stores", 5, 8'h5E);

    // R7: power lost during an active write
    drive(0,1,0,9,8'h3C);
    set_pwr(0,0,0);
    drive(1,1,1,9,8'h3C);
    set_pwr(1,0,0);
    rd_expect("R7 aborted write", 9, pat(9));

    // R8: low battery at power-up blocks exactly one write
    set_pwr(0,0,1); batt_low = 1;
    set_pwr(1,0,0);
    @(negedge clk); batt_low = 0;
    wr(20, 8'hEE, 0);
    rd_expect("R8 first write blocked", 20, pat(20));
    wr(20, 8'hEE, 2);
    rd_expect("R8 second write stores", 20, 8'hEE);
    wr(21, 8'h21, 1);
    rd_expect("R8 later write stores", 21, 8'h21);

    // R9: reset clears armed flag, keeps memory
    set_pwr(0,1,0); batt_low = 1;
    set_pwr(1,0,0);
    @(negedge clk); batt_low = 0;
    pulse_reset();
    rd_expect("R9 memory kept", 20, 8'hEE);
    wr(30, 8'h77, 0);
    rd_expect("R9 flag cleared", 30, 8'h77);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule